// File: doc/BRIEF.md
# Character Display Instruction Controller

This block is the command engine of a two-line, twenty-column character display. A host interface hands it one byte transaction per cycle. Each transaction carries a register-select bit (instruction or data), a read/write bit and an 8-bit value. The controller decodes the instruction set and keeps all of the display state: the address counter, 80 bytes of character-code memory split into two banks of 40, 64 bytes of user glyph memory, the horizontal shift offset and the mode flags.

Reads come back one cycle after the request. An address-counter read returns the counter with a busy flag that is always zero, so a host can stream transactions without ever polling. A clear instruction takes effect at once for every later transaction. The physical fill of character memory runs as a background sweep of one location per clock. The display-enable, cursor, blink, brightness, bus-width, line-count, shift-offset and cursor-position state are exported to a separate pixel scanner.

Top module: `chardisp_ctrl`

## Requirements
- R1: After reset, every character location reads 20h, the address counter is 00h and selects character memory, the shift offset is 0, the step direction is up with auto-shift off, display, cursor and blink are off, the bus width flag and line-count flag are 1, and the brightness code is 00.
- R2: With both select bits low, the highest set bit of the value picks the instruction. Bit 7 loads a character address from bits 6..0. Bit 6 loads a glyph address from bits 5..0. Bit 5 is function set (bus width bit 4, line count bit 3, brightness bits 1..0). Bit 4 is cursor/display shift. Bit 3 is display control (display bit 2, cursor bit 1, blink bit 0). Bit 2 is entry mode (direction bit 1, auto-shift bit 0). Bit 1 is home. Bit 0 alone is clear.
- R3: In character mode, stepping up goes 27h to 40h and 67h to 00h. Stepping down goes 40h to 27h and 00h to 67h. All other steps are plus or minus one.
- R4: In glyph mode, the address counter wraps between 3Fh and 00h in both directions.
- R5: A data write (select=1, write) stores the byte in the memory chosen by the last address load. A data read (select=1, read) returns that memory's byte. Either one then steps the counter in the entry direction. Read data appears on the response port with a valid strobe in the cycle after the request. Character addresses with low six bits at 28h or above hold nothing: writes to them are dropped and reads return 20h.
- R6: When auto-shift is on, a character-memory write moves the offset by +1 (direction up) or -1 (direction down), modulo 40. Reads and glyph writes never shift.
- R7: Cursor/display shift (bit 3 S, bit 2 R) steps the counter down when R=0 and up when R=1, using the character wrap rules. It moves the offset by +1 when S=1,R=0 and by -1 when S=1,R=1. Afterwards the counter addresses character memory. No memory is touched.
- R8: An address-counter read (select=0, read) returns 0 in bit 7 and the counter in bits 6..0, and changes no state.
- R9: Clear makes every character location read 20h, sets the counter to 00h in character mode, sets the offset to 0 and the direction to up. Auto-shift and glyph memory are unchanged.
- R10: Home sets the counter to 00h and the offset to 0 and leaves both memories unchanged.
- R11: A character write that follows a clear is kept, even at a location the background sweep has not yet reached.
- R12: The exported display, cursor, blink, bus width, line count and brightness outputs follow the last display control and function set values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transaction present this cycle |
| req_rs | input | 1 | 0 instruction/counter, 1 memory data |
| req_rw | input | 1 | 0 write, 1 read |
| req_data | input | 8 | Instruction or write byte |
| rsp_valid | output | 1 | Read result valid (one cycle after a read) |
| rsp_data | output | 8 | Read result |
| disp_on | output | 1 | Display enabled |
| cursor_on | output | 1 | Cursor underline enabled |
| blink_on | output | 1 | Cursor character blink enabled |
| bus_8bit | output | 1 | Host bus width flag |
| two_lines | output | 1 | Line count flag |
| bright | output | 2 | Brightness code (00 brightest) |
| shift_ofs | output | 6 | Display shift offset, 0..39 |
| cursor_addr | output | 7 | Address counter |

## Verification
The bench targets the bank seams 27h/40h and 67h/00h in both directions. A plain 7-bit counter would walk into the unmapped 28h..3Fh gap or run on to 68h. It also targets the 3Fh/00h glyph wrap, and the offset wrap at 0 and 39 under auto-shift writes. A plain modulo-64 offset would show 63 there. A write at the last location straight after a clear, read back after the sweep has passed, catches a sweep that overwrites host data. Instruction values with many bits set check the highest-bit priority: a decoder keyed on a lower bit would load the wrong register.

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl #(
  parameter int COLS = 40,
  parameter int CG_DEPTH = 64,
  parameter logic [7:0] BLANK = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_rs,
  input  logic       req_rw,
  input  logic [7:0] req_data,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       bus_8bit,
  output logic       two_lines,
  output logic [1:0] bright,
  output logic [5:0] shift_ofs,
  output logic [6:0] cursor_addr
);
  localparam int DD_DEPTH = 2 * COLS;
  localparam int DW = $clog2(DD_DEPTH);
  localparam int CW = $clog2(CG_DEPTH);
  localparam logic [5:0] LAST = 6'(COLS - 1);

  logic [7:0] dd_mem [DD_DEPTH];
  logic [7:0] cg_mem [CG_DEPTH];
  logic [DD_DEPTH-1:0] stale;
  logic sweeping;
  logic [DW-1:0] sweep_idx;
  logic [6:0] ac;
  logic cg_sel, inc, shen;
  logic [5:0] ofs;

  wire is_cmd  = req_valid & ~req_rs & ~req_rw;
  wire is_acrd = req_valid & ~req_rs &  req_rw;
  wire is_wr   = req_valid &  req_rs & ~req_rw;
  wire is_rd   = req_valid &  req_rs &  req_rw;

  wire c_dd   = is_cmd & req_data[7];
  wire c_cg   = is_cmd & (req_data[7:6] == 2'b01);
  wire c_fn   = is_cmd & (req_data[7:5] == 3'b001);
  wire c_sh   = is_cmd & (req_data[7:4] == 4'b0001);
  wire c_dc   = is_cmd & (req_data[7:3] == 5'b00001);
  wire c_em   = is_cmd & (req_data[7:2] == 6'b000001);
  wire c_home = is_cmd & (req_data[7:1] == 7'b0000001);
  wire c_clr  = is_cmd & (req_data == 8'h01);

  wire [DW-1:0] dd_idx = ac[6] ? DW'(COLS) + DW'(ac[5:0]) : DW'(ac[5:0]);
  wire dd_ok = ac[5:0] < 6'(COLS);
  wire [CW-1:0] cg_idx = ac[CW-1:0];

  function automatic logic [6:0] step_dd(input logic [6:0] a, input logic up);
    if (up) begin
      if (a == {1'b0, LAST}) return 7'h40;
      if (a == {1'b1, LAST}) return 7'h00;
      return a + 7'd1;
    end
    if (a == 7'h40) return {1'b0, LAST};
    if (a == 7'h00) return {1'b1, LAST};
    return a - 7'd1;
  endfunction

  function automatic logic [5:0] step_ofs(input logic [5:0] o, input logic up);
    if (up) return (o == LAST) ? 6'd0 : o + 6'd1;
    return (o == 6'd0) ? LAST : o - 6'd1;
  endfunction

  wire [CW-1:0] cg_next = inc ? cg_idx + CW'(1) : cg_idx - CW'(1);
  wire [6:0] ac_next = cg_sel ? 7'(cg_next) : step_dd(ac, inc);
  wire [7:0] rd_val = cg_sel ? cg_mem[cg_idx]
                    : (dd_ok && !stale[dd_idx]) ? dd_mem[dd_idx] : BLANK;

  assign cursor_addr = ac;
  assign shift_ofs = ofs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DD_DEPTH; i++) dd_mem[i] <= BLANK;
      for (int i = 0; i < CG_DEPTH; i++) cg_mem[i] <= 8'h00;
      stale <= '0;
      sweeping <= 1'b0;
      sweep_idx <= '0;
      ac <= '0;
      cg_sel <= 1'b0;
      inc <= 1'b1;
      shen <= 1'b0;
      ofs <= '0;
      disp_on <= 1'b0;
      cursor_on <= 1'b0;
      blink_on <= 1'b0;
      bus_8bit <= 1'b1;
      two_lines <= 1'b1;
      bright <= 2'b00;
      rsp_valid <= 1'b0;
      rsp_data <= '0;
    end else begin
      rsp_valid <= is_acrd | is_rd;
      if (is_acrd) rsp_data <= {1'b0, ac};
      if (is_rd) rsp_data <= rd_val;

      if (sweeping) begin
        if (stale[sweep_idx]) begin
          dd_mem[sweep_idx] <= BLANK;
          stale[sweep_idx] <= 1'b0;
        end
        if (sweep_idx == DW'(DD_DEPTH - 1)) sweeping <= 1'b0;
        sweep_idx <= sweep_idx + DW'(1);
      end

      if (is_wr) begin
        if (cg_sel) cg_mem[cg_idx] <= req_data;
        else if (dd_ok) begin
          dd_mem[dd_idx] <= req_data;
          stale[dd_idx] <= 1'b0;
        end
        ac <= ac_next;
        if (!cg_sel && shen) ofs <= step_ofs(ofs, inc);
      end
      if (is_rd) ac <= ac_next;

      if (c_dd) begin
        ac <= req_data[6:0];
        cg_sel <= 1'b0;
      end
      if (c_cg) begin
        ac <= 7'(req_data[CW-1:0]);
        cg_sel <= 1'b1;
      end
      if (c_fn) begin
        bus_8bit <= req_data[4];
        two_lines <= req_data[3];
        bright <= req_data[1:0];
      end
      if (c_sh) begin
        ac <= step_dd(ac, req_data[2]);
        cg_sel <= 1'b0;
        if (req_data[3]) ofs <= step_ofs(ofs, !req_data[2]);
      end
      if (c_dc) begin
        disp_on <= req_data[2];
        cursor_on <= req_data[1];
        blink_on <= req_data[0];
      end
      if (c_em) begin
        inc <= req_data[1];
        shen <= req_data[0];
      end
      if (c_home) begin
        ac <= '0;
        ofs <= '0;
      end
      if (c_clr) begin
        stale <= '1;
        sweeping <= 1'b1;
        sweep_idx <= '0;
        ac <= '0;
        cg_sel <= 1'b0;
        ofs <= '0;
        inc <= 1'b1;
      end
    end
  end

  assert_busy_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_acrd |=> (rsp_valid && !rsp_data[7] && rsp_data[6:0] == $past(ac)));

  assert_ofs_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ofs < 6'(COLS));

  assert_bank_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && !cg_sel && inc && ac == {1'b0, LAST}) |=> (ac == 7'h40));

  assert_cg_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && cg_sel && !inc && ac == 7'd0) |=> (ac == 7'(CG_DEPTH - 1)));

  assert_clear_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    c_clr |=> (ac == 7'd0 && ofs == 6'd0 && inc && !cg_sel));

  assert_home_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    c_home |=> (ac == 7'd0 && ofs == 6'd0));
endmodule

// File: tb/chardisp_ctrl_test.sv
module chardisp_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_rs = 1'b0, req_rw = 1'b0;
  logic [7:0] req_data = 8'h00;
  logic rsp_valid;
  logic [7:0] rsp_data;
  logic disp_on, cursor_on, blink_on, bus_8bit, two_lines;
  logic [1:0] bright;
  logic [5:0] shift_ofs;
  logic [6:0] cursor_addr;

  chardisp_ctrl uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [7:0] dd_m [80];
  logic [7:0] cg_m [64];
  logic [6:0] m_ac;
  logic m_cg, m_id, m_s, m_d, m_c, m_b, m_dl, m_n;
  logic [1:0] m_br;
  int m_ofs;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] m_step(input logic [6:0] a, input logic up);
    if (up) return (a == 7'h27) ? 7'h40 : (a == 7'h67) ? 7'h00 : a + 7'd1;
    return (a == 7'h40) ? 7'h27 : (a == 7'h00) ? 7'h67 : a - 7'd1;
  endfunction

  function automatic int m_idx(input logic [6:0] a);
    return (a[6] ? 40 : 0) + int'(a[5:0]);
  endfunction

  function automatic int m_sh(input int o, input logic up);
    return up ? (o + 1) % 40 : (o + 39) % 40;
  endfunction

  function automatic logic [7:0] m_read();
    if (m_cg) return cg_m[m_ac[5:0]];
    if (m_ac[5:0] < 6'd40) return dd_m[m_idx(m_ac)];
    return 8'h20;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 80; i++) dd_m[i] = 8'h20;
    for (int i = 0; i < 64; i++) cg_m[i] = 8'h00;
    m_ac = 0; m_cg = 0; m_id = 1; m_s = 0; m_d = 0; m_c = 0; m_b = 0;
    m_dl = 1; m_n = 1; m_br = 0; m_ofs = 0;
  endtask

  task automatic check_outs(string req);
    check(req, "cursor_addr", int'(cursor_addr), int'(m_ac));
    check(req, "shift_ofs", int'(shift_ofs), m_ofs);
    check(req, "modes", int'({disp_on, cursor_on, blink_on, bus_8bit, two_lines, bright}),
          int'({m_d, m_c, m_b, m_dl, m_n, m_br}));
  endtask

  task automatic txn(input logic rs, input logic rw, input logic [7:0] d, input string req);
    logic [7:0] exp;
    exp = 8'h00;
    req_valid = 1'b1; req_rs = rs; req_rw = rw; req_data = d;
    if (!rs && rw) exp = {1'b0, m_ac};
    else if (rs && rw) exp = m_read();
    if (rs) begin
      if (!rw) begin
        if (m_cg) cg_m[m_ac[5:0]] = d;
        else begin
          if (m_ac[5:0] < 6'd40) dd_m[m_idx(m_ac)] = d;
          if (m_s) m_ofs = m_sh(m_ofs, m_id);
        end
      end
      m_ac = m_cg ? {1'b0, m_id ? m_ac[5:0] + 6'd1 : m_ac[5:0] - 6'd1} : m_step(m_ac, m_id);
    end else if (!rw) begin
      if (d[7]) begin m_ac = d[6:0]; m_cg = 0; end
      else if (d[6]) begin m_ac = {1'b0, d[5:0]}; m_cg = 1; end
      else if (d[5]) begin m_dl = d[4]; m_n = d[3]; m_br = d[1:0]; end
      else if (d[4]) begin
        m_ac = m_step(m_ac, d[2]); m_cg = 0;
        if (d[3]) m_ofs = m_sh(m_ofs, !d[2]);
      end
      else if (d[3]) begin m_d = d[2]; m_c = d[1]; m_b = d[0]; end
      else if (d[2]) begin m_id = d[1]; m_s = d[0]; end
      else if (d[1]) begin m_ac = 0; m_ofs = 0; end
      else if (d[0]) begin
        for (int i = 0; i < 80; i++) dd_m[i] = 8'h20;
        m_ac = 0; m_cg = 0; m_ofs = 0; m_id = 1;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(req, "rsp_valid", int'(rsp_valid), int'(rw));
    if (rw) check(req, "rsp_data", int'(rsp_data), int'(exp));
    check_outs(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1");
    check("R1", "rsp_valid", int'(rsp_valid), 0);
    txn(0, 1, 8'h00, "R1");
    txn(1, 1, 8'h00, "R1");
    txn(0, 0, 8'hA7, "R2");
    txn(0, 1, 8'h00, "R2");
    txn(0, 0, 8'h7F, "R2");
    txn(0, 1, 8'h00, "R2");
    txn(0, 0, 8'h3B, "R12");
    txn(0, 0, 8'h0F, "R12");
    txn(0, 0, 8'h0A, "R12");
    txn(0, 0, 8'h20, "R12");
    txn(0, 0, 8'hA7, "R3");
    txn(1, 0, 8'h55, "R3");
    txn(0, 1, 8'h00, "R3");
    txn(0, 0, 8'hE7, "R3");
    txn(1, 0, 8'h66, "R3");
    txn(0, 0, 8'h04, "R3");
    txn(0, 0, 8'hC0, "R3");
    txn(1, 1, 8'h00, "R3");
    txn(0, 0, 8'h80, "R3");
    txn(1, 0, 8'h77, "R3");
    txn(0, 1, 8'h00, "R3");
    txn(0, 0, 8'h40, "R4");
    txn(1, 0, 8'h1F, "R4");
    txn(0, 0, 8'h06, "R4");
    txn(0, 0, 8'h7F, "R4");
    txn(1, 0, 8'h11, "R4");
    txn(0, 0, 8'h7F, "R5");
    txn(1, 1, 8'h00, "R5");
    txn(0, 0, 8'hA8, "R5");
    txn(1, 0, 8'h99, "R5");
    txn(0, 0, 8'hA8, "R5");
    txn(1, 1, 8'h00, "R5");
    txn(0, 0, 8'h05, "R6");
    txn(0, 0, 8'h85, "R6");
    txn(1, 0, 8'h31, "R6");
    txn(1, 1, 8'h00, "R6");
    txn(0, 0, 8'h07, "R6");
    txn(1, 0, 8'h32, "R6");
    txn(0, 0, 8'h50, "R6");
    txn(1, 0, 8'h33, "R6");
    txn(0, 0, 8'h1C, "R7");
    txn(0, 0, 8'h18, "R7");
    txn(0, 0, 8'h10, "R7");
    txn(0, 0, 8'h14, "R7");
    txn(0, 0, 8'h45, "R7");
    txn(0, 0, 8'h14, "R7");
    txn(0, 0, 8'h02, "R10");
    txn(0, 0, 8'hA7, "R10");
    txn(1, 1, 8'h00, "R10");
    txn(0, 0, 8'h01, "R9");
    txn(0, 0, 8'hE7, "R11");
    txn(1, 0, 8'h41, "R11");
    txn(0, 0, 8'hC5, "R9");
    txn(1, 1, 8'h00, "R9");
    repeat (100) @(negedge clk);
    txn(0, 0, 8'hE7, "R11");
    txn(1, 1, 8'h00, "R11");
    txn(0, 0, 8'h40, "R9");
    txn(1, 1, 8'h00, "R9");
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [7:0] r;
      k = int'($urandom % 100);
      r = 8'($urandom);
      if (k < 25) txn(1, 0, r, "R5");
      else if (k < 40) txn(1, 1, 8'h00, "R5");
      else if (k < 50) txn(0, 0, {1'b1, r[0], 6'($urandom % 40)}, "R2");
      else if (k < 55) txn(0, 0, {2'b01, r[5:0]}, "R4");
      else if (k < 65) txn(0, 0, {4'b0001, r[3:0]}, "R7");
      else if (k < 72) txn(0, 0, {6'b000001, r[1:0]}, "R6");
      else if (k < 77) txn(0, 0, {5'b00001, r[2:0]}, "R12");
      else if (k < 81) txn(0, 0, {3'b001, r[4:0]}, "R12");
      else if (k < 90) txn(0, 1, 8'h00, "R8");
      else if (k < 93) txn(0, 0, {7'b0000001, r[0]}, "R10");
      else if (k < 95) txn(0, 0, 8'h01, "R9");
      else begin
        req_valid = 1'b0;
        @(negedge clk);
        check("R5", "rsp_valid idle", int'(rsp_valid), 0);
      end
    end
    finish_run();
  end
endmodule